// File: doc/BRIEF.md
# Function-Level Reset Completion Manager

This block sits on the application side of a PCI Express endpoint and handles function-level resets for up to eight physical functions and their virtual functions. The link core reports a physical-function reset as a pulse on one bit of an eight-bit vector. It reports a virtual-function reset as a single pulse that carries the parent function number and the virtual-function offset. The block records each request. For each recorded function it asks the local transaction logic to drain, and only then reports back to the core that the function may be enabled again.

Physical-function requests are held as one pending bit per function. Virtual-function requests go into a small ordered queue. A single sequencer serves one function at a time. It raises a drain request that carries the function's identity and waits for the drain-done pulse. If that pulse never arrives, a timeout forces completion and sets a sticky error flag. The sequencer then presents the completion message and launches it only in a cycle where the core reports it is ready. Physical functions are served before virtual ones, and the lowest-numbered pending physical function goes first. A repeated request for a function that is already waiting is merged with the existing one.

Top module: `flr_cpl_mgr`

## Requirements
- R1: After synchronous reset, drain_req_o is 0, cpl_pf_o is 0, cpl_vf_o is 0, and both error flags are 0; a reset pulse also clears all pending requests.
- R2: A pulse on bit n of flr_pf_req_i leads to drain_req_o high with drain_is_vf_o=0 and drain_pf_o=n. After drain_done_i, a one-cycle pulse appears on cpl_pf_o bit n.
- R3: A pulse on flr_vf_req_i with parent p and offset v leads to drain_req_o high with drain_is_vf_o=1, drain_pf_o=p and drain_vf_o=v. After drain_done_i, cpl_vf_o pulses for one cycle with cpl_pf_num_o=p and cpl_vf_num_o=v.
- R4: While drain_req_o is high and neither drain_done_i has been seen nor the timeout has expired, no completion is issued.
- R5: While cpl_ready_i is low, no completion pulse is issued and cpl_pf_num_o and cpl_vf_num_o stay stable. The held completion is issued in the first cycle in which cpl_ready_i is high.
- R6: Pending physical functions are served before any queued virtual function. Among physical functions, the lowest-numbered one is served first.
- R7: A request for a function that is already waiting (a pending physical-function bit, or an identical parent/offset pair already in the queue) produces only one drain and one completion.
- R8: The virtual-function queue holds VF_DEPTH entries (default 8) and serves them in arrival order. A new, distinct request that arrives while the queue is full is dropped and sets overflow_err_o, which stays high until reset.
- R9: If drain_done_i does not arrive, drain_req_o stays high for exactly TIMEOUT_CYCLES cycles (default 64). The completion then proceeds, and timeout_err_o is set and stays high until reset.
- R10: At most one completion indication (one bit of cpl_pf_o, or cpl_vf_o) is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock shared by all requests and completions |
| rst | input | 1 | Synchronous active-high reset |
| flr_pf_req_i | input | 8 | Physical-function reset pulses, one bit per function |
| flr_vf_req_i | input | 1 | Virtual-function reset pulse |
| flr_vf_pf_i | input | 3 | Parent function number of the virtual-function request |
| flr_vf_num_i | input | 11 | Virtual-function offset of the request |
| drain_req_o | output | 1 | Asks local logic to flush the function being served |
| drain_is_vf_o | output | 1 | Function being drained is a virtual function |
| drain_pf_o | output | 3 | Physical or parent function number being drained |
| drain_vf_o | output | 11 | Virtual-function offset being drained (0 for physical) |
| drain_done_i | input | 1 | Pulse from local logic: flush finished |
| cpl_ready_i | input | 1 | Core can accept a completion message |
| cpl_pf_o | output | 8 | Physical-function completion pulse, one bit per function |
| cpl_vf_o | output | 1 | Virtual-function completion pulse |
| cpl_pf_num_o | output | 3 | Parent function number of the completion |
| cpl_vf_num_o | output | 11 | Virtual-function offset of the completion |
| overflow_err_o | output | 1 | Sticky: a virtual-function request was dropped |
| timeout_err_o | output | 1 | Sticky: a drain timed out |

## Verification
Random physical-function masks test the lowest-first ordering. Random sets of distinct virtual-function identities test arrival order. A mix of both, issued while the sequencer is busy, shows whether physical functions overtake earlier virtual ones. Random drain delays and ready-low stretches separate a design that waits for the handshakes from one that fires early or drops a held message. Directed cases cover duplicate requests (merge versus double service), a ninth queued identity (drop and flag), and a missing acknowledge (timeout length and flag).

// File: rtl/flrm_pkg.sv
package flrm_pkg;

    localparam int unsigned PF_COUNT = 8;
    localparam int unsigned PF_NUM_W = $clog2(PF_COUNT);
    localparam int unsigned VF_NUM_W = 11;

    typedef logic [PF_NUM_W-1:0] pf_num_t;
    typedef logic [VF_NUM_W-1:0] vf_num_t;
    typedef logic [PF_COUNT-1:0] pf_vec_t;

    typedef struct packed {
        pf_num_t pf;
        vf_num_t vf;
    } vf_id_t;

    typedef struct packed {
        logic    is_vf;
        pf_num_t pf;
        vf_num_t vf;
    } fn_id_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_CPL   = 2'd2
    } seq_state_t;

    function automatic pf_num_t lowest_set(input pf_vec_t m);
        pf_num_t r;
        r = '0;
        for (int i = PF_COUNT - 1; i >= 0; i--) begin
            if (m[i]) r = pf_num_t'(i);
        end
        return r;
    endfunction

    function automatic pf_vec_t pf_onehot(input pf_num_t n);
        pf_vec_t o;
        o = '0;
        o[n] = 1'b1;
        return o;
    endfunction

endpackage

// File: rtl/flrm_pf_track.sv
module flrm_pf_track
    import flrm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pf_vec_t req_i,
    input  pf_vec_t clr_i,
    output logic    any_o,
    output pf_num_t pick_o
);

    pf_vec_t pending_q;

    // A new pulse wins over a clear in the same cycle; repeats merge into the bit.
    always_ff @(posedge clk) begin
        if (rst) pending_q <= '0;
        else     pending_q <= (pending_q & ~clr_i) | req_i;
    end

    assign any_o  = |pending_q;
    assign pick_o = lowest_set(pending_q);

    assert_pf_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (req_i != '0) |=> ((pending_q & $past(req_i)) == $past(req_i)));

    assert_pick_pending_R6: assert property (@(posedge clk) disable iff (rst)
        any_o |-> pending_q[pick_o]);

endmodule

// File: rtl/flrm_vf_queue.sv
module flrm_vf_queue
    import flrm_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push_i,
    input  vf_id_t push_id_i,
    input  logic   pop_i,
    output logic   nonempty_o,
    output vf_id_t head_o,
    output logic   overflow_o
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    vf_id_t                mem_q [DEPTH];
    logic [DEPTH-1:0]      slot_vld_q;
    logic [PTR_W-1:0]      rd_ptr_q, wr_ptr_q;
    logic [CNT_W-1:0]      cnt_q;
    logic                  ovf_q;
    logic [DEPTH-1:0]      match;
    logic                  dup, full, accept, drop;

    // Duplicate search skips the head entry when it leaves in this cycle.
    for (genvar i = 0; i < DEPTH; i++) begin : g_match
        assign match[i] = slot_vld_q[i] && (mem_q[i] == push_id_i)
                          && !(pop_i && (rd_ptr_q == PTR_W'(i)));
    end

    assign dup    = |match;
    assign full   = (cnt_q == CNT_W'(DEPTH));
    assign accept = push_i && !dup && (!full || pop_i);
    assign drop   = push_i && !dup && full && !pop_i;

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_vld_q <= '0;
            rd_ptr_q   <= '0;
            wr_ptr_q   <= '0;
            cnt_q      <= '0;
            ovf_q      <= 1'b0;
        end else begin
            if (pop_i) begin
                slot_vld_q[rd_ptr_q] <= 1'b0;
                rd_ptr_q             <= next_ptr(rd_ptr_q);
            end
            if (accept) begin
                mem_q[wr_ptr_q]      <= push_id_i;
                slot_vld_q[wr_ptr_q] <= 1'b1;
                wr_ptr_q             <= next_ptr(wr_ptr_q);
            end
            cnt_q <= cnt_q + CNT_W'(accept) - CNT_W'(pop_i);
            if (drop) ovf_q <= 1'b1;
        end
    end

    assign nonempty_o = (cnt_q != '0);
    assign head_o     = mem_q[rd_ptr_q];
    assign overflow_o = ovf_q;

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        (push_i && !dup && full && !pop_i) |=> (overflow_o && cnt_q == CNT_W'(DEPTH)));

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        overflow_o |=> overflow_o);

    assert_pop_nonempty_R8: assert property (@(posedge clk) disable iff (rst)
        pop_i |-> nonempty_o);

endmodule

// File: rtl/flrm_seq.sv
module flrm_seq
    import flrm_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES = 64
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    pf_any_i,
    input  pf_num_t pf_pick_i,
    input  logic    vf_nonempty_i,
    input  vf_id_t  vf_head_i,
    input  logic    drain_done_i,
    input  logic    cpl_ready_i,
    output pf_vec_t pf_clr_o,
    output logic    vf_pop_o,
    output logic    drain_req_o,
    output fn_id_t  drain_id_o,
    output pf_vec_t cpl_pf_o,
    output logic    cpl_vf_o,
    output pf_num_t cpl_pf_num_o,
    output vf_num_t cpl_vf_num_o,
    output logic    timeout_err_o
);

    localparam int unsigned TW = $clog2(TIMEOUT_CYCLES + 1);

    seq_state_t    state_q;
    fn_id_t        cur_q;
    logic [TW-1:0] cnt_q;
    logic          terr_q;
    logic          expired, fire;

    assign expired = (cnt_q == TW'(TIMEOUT_CYCLES - 1));
    assign fire    = (state_q == ST_CPL) && cpl_ready_i;

    // Grant: physical functions first, then the queue head.
    always_comb begin
        pf_clr_o = '0;
        vf_pop_o = 1'b0;
        if (state_q == ST_IDLE) begin
            if (pf_any_i)           pf_clr_o = pf_onehot(pf_pick_i);
            else if (vf_nonempty_i) vf_pop_o = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            cnt_q   <= '0;
            terr_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (pf_any_i) begin
                        cur_q   <= '{is_vf: 1'b0, pf: pf_pick_i, vf: '0};
                        state_q <= ST_DRAIN;
                    end else if (vf_nonempty_i) begin
                        cur_q   <= '{is_vf: 1'b1, pf: vf_head_i.pf, vf: vf_head_i.vf};
                        state_q <= ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (drain_done_i) begin
                        state_q <= ST_CPL;
                    end else if (expired) begin
                        state_q <= ST_CPL;
                        terr_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_CPL: begin
                    if (cpl_ready_i) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign drain_req_o   = (state_q == ST_DRAIN);
    assign drain_id_o    = cur_q;
    assign cpl_pf_o      = (fire && !cur_q.is_vf) ? pf_onehot(cur_q.pf) : '0;
    assign cpl_vf_o      = fire && cur_q.is_vf;
    assign cpl_pf_num_o  = cur_q.pf;
    assign cpl_vf_num_o  = cur_q.vf;
    assign timeout_err_o = terr_q;

    assert_one_cpl_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cpl_pf_o, cpl_vf_o}));

    assert_wait_drain_R4: assert property (@(posedge clk) disable iff (rst)
        (drain_req_o && !drain_done_i && !expired) |=> (drain_req_o && $stable(drain_id_o)));

    assert_hold_cpl_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CPL && !cpl_ready_i) |=>
            (state_q == ST_CPL && $stable(cpl_pf_num_o) && $stable(cpl_vf_num_o)));

    assert_pf_first_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && pf_any_i) |=> (drain_req_o && !drain_id_o.is_vf));

    assert_terr_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        timeout_err_o |=> timeout_err_o);

endmodule

// File: rtl/flr_cpl_mgr.sv
module flr_cpl_mgr
    import flrm_pkg::*;
#(
    parameter int unsigned VF_DEPTH       = 8,
    parameter int unsigned TIMEOUT_CYCLES = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PF_COUNT-1:0] flr_pf_req_i,
    input  logic                flr_vf_req_i,
    input  logic [PF_NUM_W-1:0] flr_vf_pf_i,
    input  logic [VF_NUM_W-1:0] flr_vf_num_i,
    output logic                drain_req_o,
    output logic                drain_is_vf_o,
    output logic [PF_NUM_W-1:0] drain_pf_o,
    output logic [VF_NUM_W-1:0] drain_vf_o,
    input  logic                drain_done_i,
    input  logic                cpl_ready_i,
    output logic [PF_COUNT-1:0] cpl_pf_o,
    output logic                cpl_vf_o,
    output logic [PF_NUM_W-1:0] cpl_pf_num_o,
    output logic [VF_NUM_W-1:0] cpl_vf_num_o,
    output logic                overflow_err_o,
    output logic                timeout_err_o
);

    logic    pf_any, vf_nonempty, vf_pop;
    pf_num_t pf_pick;
    pf_vec_t pf_clr;
    vf_id_t  vf_head, vf_in;
    fn_id_t  drain_id;

    assign vf_in = '{pf: flr_vf_pf_i, vf: flr_vf_num_i};

    flrm_pf_track u_pf (
        .clk    (clk),
        .rst    (rst),
        .req_i  (flr_pf_req_i),
        .clr_i  (pf_clr),
        .any_o  (pf_any),
        .pick_o (pf_pick)
    );

    flrm_vf_queue #(.DEPTH(VF_DEPTH)) u_vfq (
        .clk        (clk),
        .rst        (rst),
        .push_i     (flr_vf_req_i),
        .push_id_i  (vf_in),
        .pop_i      (vf_pop),
        .nonempty_o (vf_nonempty),
        .head_o     (vf_head),
        .overflow_o (overflow_err_o)
    );

    flrm_seq #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .pf_any_i      (pf_any),
        .pf_pick_i     (pf_pick),
        .vf_nonempty_i (vf_nonempty),
        .vf_head_i     (vf_head),
        .drain_done_i  (drain_done_i),
        .cpl_ready_i   (cpl_ready_i),
        .pf_clr_o      (pf_clr),
        .vf_pop_o      (vf_pop),
        .drain_req_o   (drain_req_o),
        .drain_id_o    (drain_id),
        .cpl_pf_o      (cpl_pf_o),
        .cpl_vf_o      (cpl_vf_o),
        .cpl_pf_num_o  (cpl_pf_num_o),
        .cpl_vf_num_o  (cpl_vf_num_o),
        .timeout_err_o (timeout_err_o)
    );

    assign drain_is_vf_o = drain_id.is_vf;
    assign drain_pf_o    = drain_id.pf;
    assign drain_vf_o    = drain_id.vf;

endmodule

// File: tb/tb_flr_cpl_mgr.sv
module tb_flr_cpl_mgr;

    localparam int TIMEOUT = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  flr_pf_req_i = '0;
    logic        flr_vf_req_i = 1'b0;
    logic [2:0]  flr_vf_pf_i = '0;
    logic [10:0] flr_vf_num_i = '0;
    logic        drain_req_o, drain_is_vf_o;
    logic [2:0]  drain_pf_o;
    logic [10:0] drain_vf_o;
    logic        drain_done_i = 1'b0;
    logic        cpl_ready_i = 1'b1;
    logic [7:0]  cpl_pf_o;
    logic        cpl_vf_o;
    logic [2:0]  cpl_pf_num_o;
    logic [10:0] cpl_vf_num_o;
    logic        overflow_err_o, timeout_err_o;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    flr_cpl_mgr dut (.*);

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [2:0] low_bit(input logic [7:0] m);
        for (int i = 0; i < 8; i++) if (m[i]) return 3'(i);
        return 3'd0;
    endfunction

    task automatic pulse_pf(input logic [7:0] m);
        @(negedge clk); flr_pf_req_i = m;
        @(negedge clk); flr_pf_req_i = '0;
    endtask

    task automatic pulse_vf(input logic [2:0] p, input logic [10:0] v);
        @(negedge clk); flr_vf_req_i = 1'b1; flr_vf_pf_i = p; flr_vf_num_i = v;
        @(negedge clk); flr_vf_req_i = 1'b0;
    endtask

    // Serves one function: check drain identity, answer, check completion.
    task automatic serve(input bit isv, input logic [2:0] p, input logic [10:0] v,
                         input int dly, input int rlow, input bit no_done, input string tag);
        int w = 0;
        logic [7:0] exp_pf;
        exp_pf = isv ? 8'h00 : (8'h01 << p);
        #1;
        while (!drain_req_o && w < 400) begin @(negedge clk); #1; w++; end
        chk(drain_req_o, {tag, " drain_req"}, 32'(drain_req_o), 1);
        chk(drain_is_vf_o == isv && drain_pf_o == p && drain_vf_o == (isv ? v : 11'd0),
            {tag, " drain id"}, {drain_is_vf_o, drain_pf_o, drain_vf_o}, {isv, p, isv ? v : 11'd0});
        if (no_done) begin
            int c = 1;
            while (c < 400) begin @(negedge clk); #1; if (!drain_req_o) break; c++; end
            chk(c == TIMEOUT, "R9 timeout length", 32'(c), 32'(TIMEOUT));
        end else begin
            for (int k = 0; k < dly; k++) begin
                @(negedge clk); #1;
                chk(cpl_pf_o == 0 && !cpl_vf_o && drain_req_o, {tag, " R4 no early cpl"},
                    {cpl_pf_o, cpl_vf_o}, 0);
            end
            @(negedge clk); drain_done_i = 1'b1; cpl_ready_i = (rlow == 0);
            @(negedge clk); drain_done_i = 1'b0; #1;
            for (int k = 0; k < rlow; k++) begin
                chk(cpl_pf_o == 0 && !cpl_vf_o, {tag, " R5 held while not ready"},
                    {cpl_pf_o, cpl_vf_o}, 0);
                if (isv) chk(cpl_pf_num_o == p && cpl_vf_num_o == v, {tag, " R5 ids stable"},
                             {cpl_pf_num_o, cpl_vf_num_o}, {p, v});
                @(negedge clk);
            end
            cpl_ready_i = 1'b1; #1;
        end
        chk(cpl_pf_o == exp_pf && cpl_vf_o == isv, {tag, " R10 completion"},
            {cpl_pf_o, cpl_vf_o}, {exp_pf, isv});
        if (isv) chk(cpl_pf_num_o == p && cpl_vf_num_o == v, {tag, " R3 cpl ids"},
                     {cpl_pf_num_o, cpl_vf_num_o}, {p, v});
        @(negedge clk); #1;
        chk(cpl_pf_o == 0 && !cpl_vf_o, {tag, " one-cycle cpl"}, {cpl_pf_o, cpl_vf_o}, 0);
    endtask

    task automatic expect_idle(input string tag);
        repeat (10) @(negedge clk);
        #1;
        chk(!drain_req_o, tag, 32'(drain_req_o), 0);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        logic [10:0] vl [9];
        logic [2:0]  pl [9];
        void'($urandom(32'd20240708));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(!drain_req_o && cpl_pf_o == 0 && !cpl_vf_o && !overflow_err_o && !timeout_err_o,
            "R1 reset state", {drain_req_o, cpl_pf_o, cpl_vf_o, overflow_err_o, timeout_err_o}, 0);

        // R2 single physical function
        pulse_pf(8'h20);
        serve(0, 3'd5, 11'd0, 3, 0, 0, "R2 pf5");
        // R3 single virtual function, with ready low (R5)
        pulse_vf(3'd2, 11'h3a5);
        serve(1, 3'd2, 11'h3a5, 1, 4, 0, "R3 vf");

        // R6 random masks: lowest first
        for (int it = 0; it < 10; it++) begin
            logic [7:0] m;
            m = 8'($urandom);
            if (m == 0) m = 8'h81;
            pulse_pf(m);
            while (m != 0) begin
                logic [2:0] b;
                b = low_bit(m);
                serve(0, b, 11'd0, int'($urandom % 4), int'($urandom % 3), 0, "R6 pf order");
                m[b] = 1'b0;
            end
        end

        // R8 arrival order of random distinct virtual functions
        for (int it = 0; it < 6; it++) begin
            int n;
            n = 1 + int'($urandom % 8);
            for (int i = 0; i < n; i++) begin
                pl[i] = 3'($urandom);
                vl[i] = {8'($urandom), 3'(i)};
                pulse_vf(pl[i], vl[i]);
            end
            for (int i = 0; i < n; i++)
                serve(1, pl[i], vl[i], int'($urandom % 3), int'($urandom % 3), 0, "R8 vf order");
        end

        // R6 physical functions overtake an earlier queued virtual function
        pulse_pf(8'h01);
        pulse_vf(3'd6, 11'h077);
        pulse_pf(8'h0a);
        serve(0, 3'd0, 0, 0, 0, 0, "R6 busy pf0");
        serve(0, 3'd1, 0, 0, 0, 0, "R6 pf1 before vf");
        serve(0, 3'd3, 0, 0, 0, 0, "R6 pf3 before vf");
        serve(1, 3'd6, 11'h077, 0, 0, 0, "R6 vf last");

        // R7 merging of repeats
        pulse_pf(8'h01);
        pulse_pf(8'h10);
        pulse_pf(8'h10);
        pulse_vf(3'd1, 11'd7);
        pulse_vf(3'd1, 11'd7);
        serve(0, 3'd0, 0, 0, 0, 0, "R7 busy pf0");
        serve(0, 3'd4, 0, 0, 0, 0, "R7 pf4 once");
        serve(1, 3'd1, 11'd7, 0, 0, 0, "R7 vf once");
        expect_idle("R7 no second service");

        // R8 overflow: queue full while busy
        pulse_pf(8'h01);
        for (int i = 0; i < 9; i++) begin
            pl[i] = 3'(i);
            vl[i] = 11'(100 + i);
            pulse_vf(pl[i], vl[i]);
            if (i == 7) begin
                #1;
                chk(!overflow_err_o, "R8 no overflow at depth", 32'(overflow_err_o), 0);
            end
        end
        #1;
        chk(overflow_err_o, "R8 overflow flag", 32'(overflow_err_o), 1);
        serve(0, 3'd0, 0, 0, 0, 0, "R8 busy pf0");
        for (int i = 0; i < 8; i++) serve(1, pl[i], vl[i], 0, 0, 0, "R8 queued vf");
        expect_idle("R8 ninth dropped");
        chk(overflow_err_o, "R8 overflow sticky", 32'(overflow_err_o), 1);

        // R9 timeout
        chk(!timeout_err_o, "R9 no timeout yet", 32'(timeout_err_o), 0);
        pulse_pf(8'h40);
        serve(0, 3'd6, 0, 0, 0, 1, "R9 forced");
        chk(timeout_err_o, "R9 timeout flag", 32'(timeout_err_o), 1);
        pulse_pf(8'h04);
        serve(0, 3'd2, 0, 1, 0, 0, "R9 after timeout");
        chk(timeout_err_o, "R9 timeout sticky", 32'(timeout_err_o), 1);

        // R1 reset clears pending state and flags
        pulse_pf(8'h01);
        pulse_pf(8'h80);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        chk(!overflow_err_o && !timeout_err_o && !drain_req_o, "R1 reset clears",
            {overflow_err_o, timeout_err_o, drain_req_o}, 0);
        expect_idle("R1 pending cleared");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule